// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the host write port of a parallel NOR-style flash controller. Each clock in which the write strobe is high carries one host bus cycle: a word address and a 16-bit data word. The decoder follows the unlock-guarded command protocol across these cycles. When a sequence completes, it raises a one-clock request for a word program, a sector erase, a block erase or a whole-chip erase, together with the captured target address (and the data word, for a program). It also switches the read mode among array data, identification words and query data.

Only the low byte of each write takes part in command matching. Any cycle that breaks a sequence sends the decoder back to idle and to array-read mode, and so does a stray write while idle. While the downstream operation engine reports busy, every host write is dropped. In identification mode the block serves the manufacturer word and the device word on its read-address input. The device word comes from a parameter that chooses between the two bank-layout variants.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While `rst_n` is low, and in the first clock after its release, every request is low, `rd_mode` is 0 (array), and the sequencer is idle, so a program then needs its full unlock.
- R2: Four accepted writes produce `pgm_req` high for exactly the clock after the fourth write. The writes are low byte AAh to address 5555h, then 55h to 2AAAh, then A0h to 5555h, then any address and data. `op_addr` and `op_data` then hold the fourth write's address and full data word.
- R3: An erase has six writes: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, then a last cycle. If the last low byte is 30h at any address, `sec_erase_req` pulses in the next clock and `op_addr` holds that address.
- R4: The same six-write erase with last low byte 50h at any address pulses `blk_erase_req`, and `op_addr` holds that address.
- R5: The same six-write erase with last low byte 10h at address 5555h pulses `chip_erase_req`. A 10h at any other address is invalid.
- R6: The three-write sequence AAh@5555h, 55h@2AAAh, 90h@5555h sets `rd_mode` to 1 (identification). In that mode `id_word` is 00BFh for `rd_addr` 0, the device word for `rd_addr` 1 (2761h when `TOP_VARIANT`=0, 2762h otherwise) and 0 elsewhere. Outside that mode `id_word` is 0.
- R7: The three-write sequence ending with 98h at address 555h sets `rd_mode` to 2 (query), and it stays 2 until an exit or abort. A 98h at 5555h is invalid.
- R8: The three-write sequence ending with F0h@5555h sets `rd_mode` to 0.
- R9: An accepted write that does not match the expected cycle sends the sequencer to idle and `rd_mode` to 0, with no request. This covers a write while idle that is not AAh@5555h. A completed program or erase also leaves `rd_mode` at 0.
- R10: `wr_data[15:8]` has no effect on command matching.
- R11: A write while `busy` is high is ignored. Sequencer state and `rd_mode` are unchanged and no request follows.
- R12: The four request outputs are each one clock wide, and at most one is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one bus cycle per high clock |
| wr_addr | input | ADDR_W | Word address of the host write |
| wr_data | input | DATA_W | Data word of the host write |
| busy | input | 1 | Operation engine busy; writes are dropped |
| rd_addr | input | ADDR_W | Read address for identification words |
| pgm_req | output | 1 | Word program request pulse |
| sec_erase_req | output | 1 | Sector erase request pulse |
| blk_erase_req | output | 1 | Block erase request pulse |
| chip_erase_req | output | 1 | Chip erase request pulse |
| op_addr | output | ADDR_W | Target address captured with a request |
| op_data | output | DATA_W | Program data captured with a request |
| rd_mode | output | 2 | 0 array, 1 identification, 2 query |
| id_word | output | DATA_W | Identification word for `rd_addr` |

## Verification
A sequencer stuck in the wrong step shows up on the clock after the next accepted write. In that case a request appears where none is due, or a due one is missing, or `rd_mode` moves to the wrong value. A mode register holding a wrong value is visible at once on `id_word` for read address 0 or 1. A lost busy gate shows as a request or a mode change in the clock after a busy write. Random sequences with corrupted cycles, random upper data bytes and random busy periods drive all of these paths, and each clock is compared against a bench model.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE, SQ_U1, SQ_U2, SQ_PGM, SQ_E3, SQ_E4, SQ_E5
   } seq_st_t;

   typedef enum logic [1:0] {
      RM_ARRAY = 2'd0,
      RM_ID    = 2'd1,
      RM_QUERY = 2'd2
   } rd_mode_t;

   localparam logic [7:0] K_UNLK1 = 8'hAA;
   localparam logic [7:0] K_UNLK2 = 8'h55;
   localparam logic [7:0] K_PGM   = 8'hA0;
   localparam logic [7:0] K_ERS   = 8'h80;
   localparam logic [7:0] K_IDIN  = 8'h90;
   localparam logic [7:0] K_QRY   = 8'h98;
   localparam logic [7:0] K_EXIT  = 8'hF0;
   localparam logic [7:0] K_SEC   = 8'h30;
   localparam logic [7:0] K_BLK   = 8'h50;
   localparam logic [7:0] K_CHIP  = 8'h10;

   localparam logic [15:0] MFR_WORD  = 16'h00BF;
   localparam logic [15:0] DEV_BOTTOM = 16'h2761;
   localparam logic [15:0] DEV_TOP    = 16'h2762;

   typedef struct packed {
      logic at_a;
      logic at_b;
      logic at_q;
      logic is_unlk1;
      logic is_unlk2;
      logic is_pgm;
      logic is_ers;
      logic is_idin;
      logic is_qry;
      logic is_exit;
      logic is_sec;
      logic is_blk;
      logic is_chip;
   } cyc_hit_t;

endpackage

// File: rtl/fcd_match.sv
module fcd_match
   import flash_cmd_pkg::*;
#(
   parameter int              ADDR_W = 20,
   parameter logic [ADDR_W-1:0] UNLK_A = 'h5555,
   parameter logic [ADDR_W-1:0] UNLK_B = 'h2AAA,
   parameter logic [ADDR_W-1:0] CFI_A  = 'h555
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        code,
   output cyc_hit_t          hit
);
   always_comb begin
      hit.at_a     = (addr == UNLK_A);
      hit.at_b     = (addr == UNLK_B);
      hit.at_q     = (addr == CFI_A);
      hit.is_unlk1 = (code == K_UNLK1);
      hit.is_unlk2 = (code == K_UNLK2);
      hit.is_pgm   = (code == K_PGM);
      hit.is_ers   = (code == K_ERS);
      hit.is_idin  = (code == K_IDIN);
      hit.is_qry   = (code == K_QRY);
      hit.is_exit  = (code == K_EXIT);
      hit.is_sec   = (code == K_SEC);
      hit.is_blk   = (code == K_BLK);
      hit.is_chip  = (code == K_CHIP);
   end
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              busy,
   input  cyc_hit_t          hit,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              pgm_req,
   output logic              sec_req,
   output logic              blk_req,
   output logic              chip_req,
   output logic [ADDR_W-1:0] op_addr,
   output logic [DATA_W-1:0] op_data,
   output rd_mode_t          mode
);
   seq_st_t  st_q, st_d;
   rd_mode_t mode_d;
   logic     pgm_d, sec_d, blk_d, chip_d, take;

   assign take = wr_en & ~busy;

   always_comb begin
      st_d   = st_q;
      mode_d = mode;
      pgm_d  = 1'b0;
      sec_d  = 1'b0;
      blk_d  = 1'b0;
      chip_d = 1'b0;
      if (take) begin
         st_d   = SQ_IDLE;
         mode_d = RM_ARRAY;
         unique case (st_q)
            SQ_IDLE: if (hit.at_a && hit.is_unlk1) begin
               st_d = SQ_U1; mode_d = mode;
            end
            SQ_U1: if (hit.at_b && hit.is_unlk2) begin
               st_d = SQ_U2; mode_d = mode;
            end
            SQ_U2: begin
               if (hit.at_a && hit.is_pgm) begin
                  st_d = SQ_PGM; mode_d = mode;
               end else if (hit.at_a && hit.is_ers) begin
                  st_d = SQ_E3; mode_d = mode;
               end else if (hit.at_a && hit.is_idin) begin
                  mode_d = RM_ID;
               end else if (hit.at_q && hit.is_qry) begin
                  mode_d = RM_QUERY;
               end
            end
            SQ_PGM: pgm_d = 1'b1;
            SQ_E3: if (hit.at_a && hit.is_unlk1) begin
               st_d = SQ_E4; mode_d = mode;
            end
            SQ_E4: if (hit.at_b && hit.is_unlk2) begin
               st_d = SQ_E5; mode_d = mode;
            end
            SQ_E5: begin
               sec_d  = hit.is_sec;
               blk_d  = hit.is_blk;
               chip_d = hit.is_chip & hit.at_a;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= SQ_IDLE;
         mode     <= RM_ARRAY;
         pgm_req  <= 1'b0;
         sec_req  <= 1'b0;
         blk_req  <= 1'b0;
         chip_req <= 1'b0;
         op_addr  <= '0;
         op_data  <= '0;
      end else begin
         st_q     <= st_d;
         mode     <= mode_d;
         pgm_req  <= pgm_d;
         sec_req  <= sec_d;
         blk_req  <= blk_d;
         chip_req <= chip_d;
         if (pgm_d | sec_d | blk_d | chip_d) begin
            op_addr <= wr_addr;
            op_data <= wr_data;
         end
      end
   end
endmodule

// File: rtl/fcd_idrom.sv
module fcd_idrom
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W      = 20,
   parameter int DATA_W      = 16,
   parameter int TOP_VARIANT = 0
) (
   input  rd_mode_t          mode,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] id_word
);
   logic [15:0] dev_word;

   generate
      if (TOP_VARIANT != 0) begin : g_top
         assign dev_word = DEV_TOP;
      end else begin : g_bottom
         assign dev_word = DEV_BOTTOM;
      end
   endgenerate

   always_comb begin
      id_word = '0;
      if (mode == RM_ID) begin
         if (rd_addr == ADDR_W'(0))      id_word = DATA_W'(MFR_WORD);
         else if (rd_addr == ADDR_W'(1)) id_word = DATA_W'(dev_word);
      end
   end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
   import flash_cmd_pkg::*;
#(
   parameter int                ADDR_W      = 20,
   parameter int                DATA_W      = 16,
   parameter int                TOP_VARIANT = 0,
   parameter logic [ADDR_W-1:0] UNLK_A      = 'h5555,
   parameter logic [ADDR_W-1:0] UNLK_B      = 'h2AAA,
   parameter logic [ADDR_W-1:0] CFI_A       = 'h555
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              busy,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              pgm_req,
   output logic              sec_erase_req,
   output logic              blk_erase_req,
   output logic              chip_erase_req,
   output logic [ADDR_W-1:0] op_addr,
   output logic [DATA_W-1:0] op_data,
   output logic [1:0]        rd_mode,
   output logic [DATA_W-1:0] id_word
);
   localparam int CODE_W = 8;

   generate
      if (ADDR_W < 16) begin : g_bad_addr
         $error("flash_cmd_decoder: ADDR_W must be at least 16");
      end
      if (DATA_W < 16) begin : g_bad_data
         $error("flash_cmd_decoder: DATA_W must be at least 16");
      end
   endgenerate

   cyc_hit_t hit;
   rd_mode_t mode;

   fcd_match #(
      .ADDR_W(ADDR_W), .UNLK_A(UNLK_A), .UNLK_B(UNLK_B), .CFI_A(CFI_A)
   ) u_match (
      .addr (wr_addr),
      .code (wr_data[CODE_W-1:0]),
      .hit  (hit)
   );

   fcd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .busy     (busy),
      .hit      (hit),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .pgm_req  (pgm_req),
      .sec_req  (sec_erase_req),
      .blk_req  (blk_erase_req),
      .chip_req (chip_erase_req),
      .op_addr  (op_addr),
      .op_data  (op_data),
      .mode     (mode)
   );

   fcd_idrom #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TOP_VARIANT(TOP_VARIANT)
   ) u_idrom (
      .mode    (mode),
      .rd_addr (rd_addr),
      .id_word (id_word)
   );

   assign rd_mode = mode;
endmodule

// File: rtl/fcd_chk.sv
module fcd_chk #(
   parameter int                ADDR_W = 20,
   parameter int                DATA_W = 16,
   parameter logic [ADDR_W-1:0] UNLK_A = 'h5555
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              busy,
   input logic              pgm_req,
   input logic              sec_erase_req,
   input logic              blk_erase_req,
   input logic              chip_erase_req,
   input logic [1:0]        rd_mode,
   input logic [DATA_W-1:0] id_word
);
   logic any_req;
   assign any_req = pgm_req | sec_erase_req | blk_erase_req | chip_erase_req;

   AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pgm_req, sec_erase_req, blk_erase_req, chip_erase_req})); // R12

   AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      any_req |=> !any_req); // R12

   AST_REQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      any_req |-> $past(wr_en && !busy)); // R2

   AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && busy) |=> (!any_req && $stable(rd_mode))); // R11

   AST_CHIP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      chip_erase_req |-> ($past(wr_addr) == UNLK_A)); // R5

   AST_MODE_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rd_mode) |-> $past(wr_en)); // R9

   AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      rd_mode != 2'd3); // R7

   AST_ID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_mode != 2'd1) |-> (id_word == '0)); // R6
endmodule

bind flash_cmd_decoder fcd_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .UNLK_A(UNLK_A)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .wr_en          (wr_en),
   .wr_addr        (wr_addr),
   .busy           (busy),
   .pgm_req        (pgm_req),
   .sec_erase_req  (sec_erase_req),
   .blk_erase_req  (blk_erase_req),
   .chip_erase_req (chip_erase_req),
   .rd_mode        (rd_mode),
   .id_word        (id_word)
);

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
   localparam int TCLK = 10;
   localparam int AW   = 20;
   localparam int DW   = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          busy = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic          pgm_req, sec_erase_req, blk_erase_req, chip_erase_req;
   logic [AW-1:0] op_addr;
   logic [DW-1:0] op_data;
   logic [1:0]    rd_mode;
   logic [DW-1:0] id_word;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 0;

   always #(TCLK/2) clk = ~clk;

   flash_cmd_decoder u_flash_cmd_decoder (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .busy(busy), .rd_addr(rd_addr),
      .pgm_req(pgm_req), .sec_erase_req(sec_erase_req),
      .blk_erase_req(blk_erase_req), .chip_erase_req(chip_erase_req),
      .op_addr(op_addr), .op_data(op_data), .rd_mode(rd_mode),
      .id_word(id_word)
   );

   // bench model: step 0 idle, 1/2 unlocked, 3 program pending, 4/5/6 erase steps
   int            m_st = 0;
   logic [1:0]    m_mode = 2'd0;
   logic          e_pgm, e_se, e_be, e_ce;
   logic [AW-1:0] e_addr = '0;
   logic [DW-1:0] e_data = '0;

   function automatic logic [DW-1:0] exp_id(logic [1:0] md, logic [AW-1:0] ra);
      if (md != 2'd1) return '0;
      if (ra == 0) return 16'h00BF;
      if (ra == 1) return 16'h2761;
      return '0;
   endfunction

   task automatic model(input logic en, input logic bsy,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
      logic [7:0] c;
      int nx;
      logic [1:0] nm;
      c = d[7:0];
      e_pgm = 0; e_se = 0; e_be = 0; e_ce = 0;
      if (!en || bsy) return;
      nx = 0; nm = 2'd0;
      case (m_st)
         0: if (a == 20'h5555 && c == 8'hAA) begin nx = 1; nm = m_mode; end
         1: if (a == 20'h2AAA && c == 8'h55) begin nx = 2; nm = m_mode; end
         2: begin
            if (a == 20'h5555 && c == 8'hA0) begin nx = 3; nm = m_mode; end
            else if (a == 20'h5555 && c == 8'h80) begin nx = 4; nm = m_mode; end
            else if (a == 20'h5555 && c == 8'h90) nm = 2'd1;
            else if (a == 20'h0555 && c == 8'h98) nm = 2'd2;
         end
         3: e_pgm = 1;
         4: if (a == 20'h5555 && c == 8'hAA) begin nx = 5; nm = m_mode; end
         5: if (a == 20'h2AAA && c == 8'h55) begin nx = 6; nm = m_mode; end
         6: begin
            e_se = (c == 8'h30);
            e_be = (c == 8'h50);
            e_ce = (c == 8'h10) && (a == 20'h5555);
         end
         default: ;
      endcase
      if (e_pgm | e_se | e_be | e_ce) begin e_addr = a; e_data = d; end
      m_st = nx; m_mode = nm;
   endtask

   task automatic fail_line(string tag, string fld, logic [31:0] act, logic [31:0] exp);
      $display("FAIL %s %s actual=%0h expected=%0h", tag, fld, act, exp);
   endtask

   task automatic compare(string tag);
      bit bad = 0;
      n_vec++;
      if (pgm_req !== e_pgm) begin fail_line({tag, "/R2"}, "pgm_req", 32'(pgm_req), 32'(e_pgm)); bad = 1; end
      if (sec_erase_req !== e_se) begin fail_line({tag, "/R3"}, "sec_erase_req", 32'(sec_erase_req), 32'(e_se)); bad = 1; end
      if (blk_erase_req !== e_be) begin fail_line({tag, "/R4"}, "blk_erase_req", 32'(blk_erase_req), 32'(e_be)); bad = 1; end
      if (chip_erase_req !== e_ce) begin fail_line({tag, "/R5"}, "chip_erase_req", 32'(chip_erase_req), 32'(e_ce)); bad = 1; end
      if ((e_pgm | e_se | e_be | e_ce) && op_addr !== e_addr) begin
         fail_line({tag, "/R3"}, "op_addr", 32'(op_addr), 32'(e_addr)); bad = 1;
      end
      if (e_pgm && op_data !== e_data) begin
         fail_line({tag, "/R2"}, "op_data", 32'(op_data), 32'(e_data)); bad = 1;
      end
      if (rd_mode !== m_mode) begin fail_line({tag, "/R9"}, "rd_mode", 32'(rd_mode), 32'(m_mode)); bad = 1; end
      if (id_word !== exp_id(m_mode, rd_addr)) begin
         fail_line({tag, "/R6"}, "id_word", 32'(id_word), 32'(exp_id(m_mode, rd_addr))); bad = 1;
      end
      if (bad) n_bad++;
   endtask

   // called at a falling edge; leaves the bench at the next falling edge
   task automatic apply(string tag, logic en, logic [AW-1:0] a, logic [DW-1:0] d,
                        logic bsy, logic [AW-1:0] ra);
      wr_en = en; wr_addr = a; wr_data = d; busy = bsy; rd_addr = ra;
      model(en, bsy, a, d);
      @(negedge clk);
      compare(tag);
   endtask

   task automatic wr(string tag, logic [AW-1:0] a, logic [7:0] c);
      apply(tag, 1'b1, a, {8'($urandom_range(0, 255)), c}, 1'b0, 20'(1));
   endtask

   task automatic idle(string tag, logic [AW-1:0] ra);
      apply(tag, 1'b0, '0, '0, 1'b0, ra);
   endtask

   task automatic unlock(string tag);
      wr(tag, 20'h5555, 8'hAA);
      wr(tag, 20'h2AAA, 8'h55);
   endtask

   task automatic random_seq();
      logic [AW-1:0] aa[6];
      logic [7:0]    cc[6];
      int n, k;
      k = $urandom_range(0, 7);
      aa[0] = 20'h5555; cc[0] = 8'hAA;
      aa[1] = 20'h2AAA; cc[1] = 8'h55;
      aa[2] = 20'h5555; aa[3] = 20'h5555; cc[3] = 8'hAA;
      aa[4] = 20'h2AAA; cc[4] = 8'h55;
      aa[5] = 20'($urandom); cc[5] = 8'h30;
      n = 3;
      case (k)
         0: begin cc[2] = 8'hA0; n = 4; aa[3] = 20'($urandom); cc[3] = 8'($urandom); end
         1: begin cc[2] = 8'h80; n = 6; end
         2: begin cc[2] = 8'h80; n = 6; cc[5] = 8'h50; end
         3: begin cc[2] = 8'h80; n = 6; cc[5] = 8'h10; aa[5] = 20'h5555; end
         4: cc[2] = 8'h90;
         5: begin cc[2] = 8'h98; aa[2] = 20'h0555; end
         6: cc[2] = 8'hF0;
         default: begin n = 1; aa[0] = 20'($urandom); cc[0] = 8'($urandom); end
      endcase
      if ($urandom_range(0, 9) == 0) begin
         int j = $urandom_range(0, n - 1);
         cc[j] = cc[j] ^ 8'(1 << $urandom_range(0, 7));
      end
      for (int i = 0; i < n; i++) begin
         logic b = ($urandom_range(0, 11) == 0);
         apply("RND", 1'b1, aa[i], {8'($urandom), cc[i]}, b,
               20'($urandom_range(0, 3)));
         if ($urandom_range(0, 5) == 0)
            apply("RND", 1'b0, '0, '0, 1'b0, 20'($urandom_range(0, 3)));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1: outputs quiet during and after reset
      compare("R1");
      rst_n = 1'b1;
      idle("R1", 20'(0));
      wr("R1", 20'h2AAA, 8'h55);          // not a start, stays idle
      wr("R1", 20'h0123, 8'hBE);

      // R2: program with full word captured
      unlock("R2");
      wr("R2", 20'h5555, 8'hA0);
      apply("R2", 1'b1, 20'h12345, 16'hBEEF, 1'b0, 20'(1));
      idle("R12", 20'(0));                // pulse gone after one clock

      // R3 and R10: sector erase with arbitrary upper data bytes
      unlock("R3"); wr("R3", 20'h5555, 8'h80); unlock("R3");
      apply("R10", 1'b1, 20'h40400, 16'hC330, 1'b0, 20'(0));
      idle("R12", 20'(0));

      // R4: block erase
      unlock("R4"); wr("R4", 20'h5555, 8'h80); unlock("R4");
      apply("R4", 1'b1, 20'hF8000, 16'h0050, 1'b0, 20'(0));

      // R5: chip erase and a misplaced chip code
      unlock("R5"); wr("R5", 20'h5555, 8'h80); unlock("R5");
      wr("R5", 20'h5555, 8'h10);
      unlock("R5"); wr("R5", 20'h5555, 8'h80); unlock("R5");
      wr("R5", 20'h01234, 8'h10);

      // R6: identification words
      unlock("R6"); wr("R6", 20'h5555, 8'h90);
      idle("R6", 20'(0)); idle("R6", 20'(1)); idle("R6", 20'(2));

      // R11: busy writes ignored, mode held, no advance
      apply("R11", 1'b1, 20'h5555, 16'h00AA, 1'b1, 20'(0));
      apply("R11", 1'b1, 20'h2AAA, 16'h0055, 1'b1, 20'(0));
      apply("R11", 1'b1, 20'h5555, 16'h00F0, 1'b1, 20'(0));
      idle("R11", 20'(1));

      // R8: exit to array
      unlock("R8"); wr("R8", 20'h5555, 8'hF0); idle("R8", 20'(0));

      // R7: query entry, wrong address for query code
      unlock("R7"); wr("R7", 20'h0555, 8'h98); idle("R7", 20'(0));
      unlock("R7"); wr("R7", 20'h5555, 8'h98);

      // R9: abort mid sequence from id mode, and stray write in id mode
      unlock("R9"); wr("R9", 20'h5555, 8'h90);
      wr("R9", 20'h5555, 8'hAA); wr("R9", 20'h2AAB, 8'h55);
      unlock("R9"); wr("R9", 20'h5555, 8'h90);
      wr("R9", 20'h00777, 8'h12);

      // R1: reset mid sequence clears mode and step
      unlock("R1"); wr("R1", 20'h5555, 8'h90);
      unlock("R1");
      rst_n = 1'b0; m_st = 0; m_mode = 2'd0;
      @(negedge clk);
      rst_n = 1'b1;
      idle("R1", 20'(0));
      wr("R1", 20'h5555, 8'hA0);

      for (int s = 0; s < 600; s++) random_seq();

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule